// File: doc/BRIEF.md
# Serial Control Port with Frame-Length Guard

This block is the serial front end of a three-channel half-bridge driver. A host selects it by pulling the chip-select low and clocks a 16-bit control word in least-significant bit first. At the same time the block shifts a 16-bit diagnostic word out, also least-significant bit first. The diagnostic word is captured from a parallel status input when chip-select falls, so bit 0 (the thermal-warning flag) is on the serial output before any serial clock edge. Bits that arrive after the first 16 pass through the shift register to the serial output, so several devices can share one chip-select in a daisy chain.

When chip-select rises, the block checks how many serial-clock rising edges it counted during the frame. It accepts the frame only if that count is a non-zero multiple of 16 and the serial clock is low at that moment. On an accepted frame it loads the last 16 bits received into the control register and raises a one-cycle pulse, which the fault logic uses to clear its latched status. On any other frame the control register is left as it was.

All serial pins are brought into the system clock domain through synchronizers. Edge detection runs on those synchronized levels. Each result at the outputs is therefore due `SYNC_STAGES + 1` system-clock edges after the pin change that causes it.

Top module: `spi_frame_slave`

## Requirements
- R1: While rst_ni is low and after reset, ctrl_o is 0, frame_ok_o is 0 and so_oe_o is 0.
- R2: so_oe_o is 1 only while chip-select is low, and returns to 0 once chip-select is high (the output is high-impedance).
- R3: After chip-select falls and before any serial-clock edge, so_o shows status_i bit 0 as it was at the falling edge.
- R4: After the k-th serial-clock rising edge of a frame, so_o shows bit k of the status word captured at the falling edge (LSB first). Bits 7 to 12 always read 0. Changes on status_i during the frame have no effect on so_o.
- R5: SI is sampled on serial-clock rising edges, LSB first. An accepted frame loads ctrl_o and raises frame_ok_o for exactly one system-clock cycle.
- R6: For a frame of 32 or 48 edges, after the first 16 edges so_o repeats the SI bits delayed by 16 edges. On acceptance ctrl_o holds the last 16 bits received, where the bit received last is bit 15.
- R7: A frame whose edge count is 0 or is not a multiple of 16 leaves ctrl_o unchanged and produces no frame_ok_o pulse.
- R8: A frame that ends with the serial clock high is rejected, even when its edge count is a multiple of 16.
- R9: Serial-clock edges while chip-select is high are ignored. They change neither ctrl_o nor the count used for the next frame, and they produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csb_i | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in |
| status_i | input | 16 | Parallel diagnostic word; bit 0 is the thermal warning |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial output enable; 0 means high-impedance |
| ctrl_o | output | 16 | Control register |
| frame_ok_o | output | 1 | One-cycle pulse on each accepted frame |

## Verification
Every output change lands three system-clock edges after the pin change that causes it: two synchronizer stages, then the registered action. The bench drives pins on falling clock edges and holds each pin level for four cycles before it samples on a falling edge. Each sample is therefore taken after the result has settled and before the next stimulus. A frame_ok_o pulse can fall between samples, so a separate counter tallies the pulses and the bench compares that tally before and after each frame.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned RSV_LO = 7;
  localparam int unsigned RSV_HI = 12;

  // status bits that always read as zero
  function automatic logic [WORD_W-1:0] status_mask();
    logic [WORD_W-1:0] m;
    for (int unsigned i = 0; i < WORD_W; i++)
      m[i] = !((i >= RSV_LO) && (i <= RSV_HI));
    return m;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctr.sv
module spi_frame_ctr #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic edge_i,
  input  logic end_i,
  input  logic sclk_lvl_i,
  output logic ok_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      seen_q <= 1'b1;
    end
  end

  assign ok_o = end_i && seen_q && (cnt_q == '0) && !sclk_lvl_i;

  // idle edges (chip-select high) must not move the counter
  assert_cnt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && !start_i) |=> ($stable(cnt_q) && $stable(seen_q)));
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic              shift_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] par_i,
  output logic              active_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      active_q <= 1'b0;
    end else begin
      if (load_i)      active_q <= 1'b1;
      else if (stop_i) active_q <= 1'b0;
      if (load_i)                   sh_q <= par_i;
      else if (shift_i && active_q) sh_q <= {si_i, sh_q[WORD_W-1:1]};
    end
  end

  assign active_o = active_q;
  assign so_oe_o  = active_q;
  assign so_o     = active_q & sh_q[0];
  assign word_o   = sh_q;

  assert_oe_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !so_oe_o);

  assert_tw_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (so_oe_o && (so_o == $past(par_i[0]))));
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_slave_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_i,
  input  logic              sclk_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              frame_ok_o
);
  localparam logic [WORD_W-1:0] STATUS_MASK = status_mask();

  logic [2:0] pins_s;
  logic       csb_s, sclk_s, si_s;
  logic       csb_d, sclk_d;
  logic       csb_fall, csb_rise, sclk_rise;
  logic       active, ok_c;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] ctrl_q;
  logic              ok_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({csb_i, sclk_i, si_i}),
    .q_o (pins_s)
  );
  assign {csb_s, sclk_s, si_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csb_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csb_d  <= csb_s;
      sclk_d <= sclk_s;
    end
  end

  assign csb_fall  = csb_d & ~csb_s;
  assign csb_rise  = ~csb_d & csb_s;
  assign sclk_rise = ~sclk_d & sclk_s;

  spi_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i   (csb_fall),
    .stop_i   (csb_rise),
    .shift_i  (sclk_rise),
    .si_i     (si_s),
    .par_i    (status_i & STATUS_MASK),
    .active_o (active),
    .so_o     (so_o),
    .so_oe_o  (so_oe_o),
    .word_o   (word)
  );

  spi_frame_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i, .rst_ni,
    .start_i    (csb_fall),
    .edge_i     (sclk_rise & active),
    .end_i      (csb_rise),
    .sclk_lvl_i (sclk_s),
    .ok_o       (ok_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= ok_c;
      if (ok_c) ctrl_q <= word;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign frame_ok_o = ok_q;

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |=> !frame_ok_o);

  assert_ctrl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ok_o |-> $stable(ctrl_o));

  assert_sclk_high_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_rise && sclk_s) |=> !frame_ok_o);
endmodule

// File: tb/spi_frame_slave_bench.sv
module spi_frame_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int NVEC       = 9;
  localparam logic [15:0] SMASK = 16'hE07F; // bits 7..12 read 0

  // {edges[6], si[48], status[16], sclk_high_at_end[1]}
  localparam logic [70:0] VECS [NVEC] = '{
    {6'd16, 48'h0000_0000_A5C3, 16'h8041, 1'b0},
    {6'd16, 48'h0000_0000_1234, 16'hFFFF, 1'b0},
    {6'd8,  48'h0000_0000_00FF, 16'h2006, 1'b0},
    {6'd32, 48'h0000_BEEF_CAFE, 16'h4078, 1'b0},
    {6'd17, 48'h0000_0001_5555, 16'h0001, 1'b0},
    {6'd16, 48'h0000_0000_7E81, 16'h8000, 1'b1},
    {6'd48, 48'h0F0F_0000_3333, 16'hA0AA, 1'b0},
    {6'd0,  48'h0000_0000_0000, 16'h0001, 1'b0},
    {6'd16, 48'h0000_0000_00C0, 16'h0000, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [15:0] status = '0;
  logic so, so_oe, frame_ok;
  logic [15:0] ctrl;
  int checks = 0, fails = 0, pulses = 0;
  logic [15:0] exp_ctrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_slave u_spi_frame_slave (
    .clk_i(clk), .rst_ni, .csb_i(csb), .sclk_i(sclk), .si_i(si),
    .status_i(status), .so_o(so), .so_oe_o(so_oe),
    .ctrl_o(ctrl), .frame_ok_o(frame_ok)
  );

  always @(posedge clk) if (frame_ok) pulses <= pulses + 1;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic [47:0] w, input logic [15:0] st,
                           input logic hi);
    logic [63:0] stream;
    int p0;
    logic acc;
    stream = {w, st & SMASK};
    p0 = pulses;
    status = st;
    @(negedge clk) csb = 1'b0;
    settle();
    check(so_oe === 1'b1, "R2 oe on", {31'd0, so_oe}, 1);
    check(so === stream[0], "R3 tw first", {31'd0, so}, {31'd0, stream[0]});
    for (int i = 0; i < n; i++) begin
      si = w[i];
      if (i == 0) status = ~st; // must not leak into the outgoing word (R4)
      settle();
      sclk = 1'b1;
      settle();
      check(so === stream[i+1], (i < 15) ? "R4 so bit" : "R6 so passthru",
            i + 1, {31'd0, stream[i+1]});
      if (!(hi && i == n - 1)) begin
        sclk = 1'b0;
        settle();
      end
    end
    csb = 1'b1;
    settle();
    check(so_oe === 1'b0, "R2 oe off", {31'd0, so_oe}, 0);
    if (hi) begin
      sclk = 1'b0;
      settle();
    end
    acc = (n != 0) && (n % 16 == 0) && !hi;
    if (acc) exp_ctrl = 16'(w >> (n - 16));
    check(ctrl === exp_ctrl, acc ? "R5/R6 ctrl load" : (hi ? "R8 ctrl hold" : "R7 ctrl hold"),
          {16'd0, ctrl}, {16'd0, exp_ctrl});
    check((pulses - p0) == (acc ? 1 : 0), acc ? "R5 one pulse" : "R7/R8 no pulse",
          pulses - p0, acc ? 1 : 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctrl === 16'h0 && frame_ok === 1'b0 && so_oe === 1'b0, "R1 in reset",
          {15'd0, frame_ok, ctrl}, 0);
    rst_ni = 1'b1;
    settle();
    check(ctrl === 16'h0 && frame_ok === 1'b0 && so_oe === 1'b0, "R1 after reset",
          {15'd0, frame_ok, ctrl}, 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(int'(VECS[v][70:65]), VECS[v][64:17], VECS[v][16:1], VECS[v][0]);

    // R9: clock activity with chip-select high is ignored
    begin
      int p0;
      p0 = pulses;
      si = 1'b1;
      for (int i = 0; i < 16; i++) begin
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
      end
      check(ctrl === exp_ctrl, "R9 ctrl hold", {16'd0, ctrl}, {16'd0, exp_ctrl});
      check(pulses == p0, "R9 no pulse", pulses - p0, 0);
      check(so_oe === 1'b0, "R9 oe off", {31'd0, so_oe}, 0);
    end
    // R9: the idle edges must not pre-load the counter of the next frame
    run_frame(8, 48'h0000_0000_0055, 16'h0003, 1'b0);
    run_frame(16, 48'h0000_0000_9C3A, 16'h6001, 1'b0);

    summary();
  end
endmodule